// File: doc/BRIEF.md
# Instruction Group Register Hazard Checker

This block watches a stream of 128-bit instruction bundles, one per cycle when `bnd_valid` is high, and reports register dependency violations that occur inside an instruction group. Each bundle carries three 41-bit instruction slots above a 5-bit template field. A group is the run of slots between two stop marks, and it may cover several bundles. For every slot the surrounding decoder supplies one destination and two source register references, each a class code plus a register number with its own valid flag. The per-slot stop marks and the slot valid flags also arrive already decoded. The checker reads the qualifying-predicate field of each slot directly from the raw bundle and treats it as a predicate read.

Inside a group, reading a register written earlier in that group (read-after-write) or writing it a second time (write-after-write) is illegal. The block does not stall on these hazards. It flags them with a one-cycle report that gives the bundle index, the slot, the kind of hazard and the offending register. The checker keeps a flat vector of written registers across all classes. It walks the three slots in order within one cycle and clears the vector after any slot that carries a stop.

Top module: `hzd_group_checker`

## Requirements
- R1: After reset no violation is reported, the group tracker is empty and the bundle index starts at 0.
- R2: A source (qualifying predicate, source A or source B) that names a register written by an earlier slot of the same group, in the same bundle or an earlier one, raises `viol_pulse` for one cycle, in the cycle after the bundle is accepted, with `viol_kind`=0 (read-after-write) and the slot, class and number of that register.
- R3: A destination that names a register already written earlier in the group raises `viol_pulse` with `viol_kind`=1 (write-after-write).
- R4: Two reads of one register, a read followed by a later write of it, and an instruction that reads and writes the same register are all legal and raise no report.
- R5: A stop mark on slot k clears the written set for slots after k and for later bundles. The stop mark applies even when slot k is not valid.
- R6: The qualifying predicate of slot k is bits [5+41k +: 6] of `bnd_raw` and counts as a read of predicate register p<qp>. The template bits [4:0] and the other slot bits have no effect.
- R7: Registers r0, f0, f1 and p0 are constants. Reading them never raises a hazard, and writing them is not tracked.
- R8: Class codes are integer=0, floating-point=1, predicate=2, branch=3, application=4. Codes 5 to 7 are ignored. The same number in different classes never conflicts. A number is reduced modulo its class size (128, 128, 64, 8, 128), and the reduced number is what gets reported.
- R9: At most one report is made per bundle. The lowest slot with a hazard wins. Within a slot the check order is qualifying predicate, source A, source B, then destination. A slot's destination is recorded even when that slot itself violates.
- R10: `viol_bundle` gives the number of bundles accepted before the offending one, modulo 2^CNT_W.
- R11: An invalid slot contributes no reads and no writes. A cycle without `bnd_valid` produces no report and changes neither the tracker nor the bundle index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bnd_valid | input | 1 | A bundle is presented this cycle |
| bnd_raw | input | 128 | Raw bundle: template [4:0], slot k at [5+41k +: 41] |
| slot_valid | input | 3 | Slot k holds a real instruction |
| slot_stop | input | 3 | Group ends after slot k |
| dst_vld | input | 3 | Slot k has a destination |
| dst_cls | input | 9 | Destination class, slot k at [3k +: 3] |
| dst_num | input | 21 | Destination number, slot k at [7k +: 7] |
| srca_vld | input | 3 | Slot k has source A |
| srca_cls | input | 9 | Source A class per slot |
| srca_num | input | 21 | Source A number per slot |
| srcb_vld | input | 3 | Slot k has source B |
| srcb_cls | input | 9 | Source B class per slot |
| srcb_num | input | 21 | Source B number per slot |
| viol_pulse | output | 1 | One-cycle violation report |
| viol_kind | output | 1 | 0 read-after-write, 1 write-after-write |
| viol_slot | output | 2 | Slot of the offending instruction |
| viol_cls | output | 3 | Class of the offending register |
| viol_num | output | 7 | Reduced number of the offending register |
| viol_bundle | output | CNT_W | Index of the offending bundle |

## Verification
The bench goes after hazards that cross a bundle boundary and hazards that a stop should hide, including a stop on an invalid slot. A design that cleared the set per bundle, or that ignored stops on empty slots, would miss or invent reports in these cases. It also places the qualifying-predicate field in each slot position, writes and reads the constant registers, and aliases numbers across classes and modulo class size, where a wrong field offset or a wrong mask shows up as a wrong or missing report. Priority cases with several hazards in one bundle catch a design that picks the wrong slot or the wrong operand. A run past the index width catches a counter that does not wrap or that counts idle cycles.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int CLS_W  = 3;
    localparam int NUM_W  = 7;
    localparam int SLOTS  = 3;
    localparam int SLOT_W = 41;
    localparam int TMPL_W = 5;
    localparam int QP_W   = 6;

    typedef enum logic [CLS_W-1:0] {
        RC_INT = 3'd0,
        RC_FP  = 3'd1,
        RC_PR  = 3'd2,
        RC_BR  = 3'd3,
        RC_AR  = 3'd4
    } rcls_e;

    typedef enum logic {
        VK_RAW = 1'b0,
        VK_WAW = 1'b1
    } vkind_e;

    typedef enum logic {
        GS_EMPTY = 1'b0,
        GS_OPEN  = 1'b1
    } gstate_e;

    typedef struct packed {
        logic             vld;
        logic [CLS_W-1:0] cls;
        logic [NUM_W-1:0] num;
    } rref_t;

endpackage

// File: rtl/hzd_regmap.sv
module hzd_regmap
    import hzd_pkg::*;
#(
    parameter int N_INT = 128,
    parameter int N_FP  = 128,
    parameter int N_PR  = 64,
    parameter int N_BR  = 8,
    parameter int N_AR  = 128,
    localparam int TOT   = N_INT + N_FP + N_PR + N_BR + N_AR,
    localparam int IDX_W = $clog2(TOT)
) (
    input  rref_t            r,
    output logic [IDX_W-1:0] idx,
    output logic             live,
    output logic [NUM_W-1:0] num_m
);

    localparam logic [IDX_W-1:0] B_FP = IDX_W'(N_INT);
    localparam logic [IDX_W-1:0] B_PR = IDX_W'(N_INT + N_FP);
    localparam logic [IDX_W-1:0] B_BR = IDX_W'(N_INT + N_FP + N_PR);
    localparam logic [IDX_W-1:0] B_AR = IDX_W'(N_INT + N_FP + N_PR + N_BR);

    localparam logic [NUM_W-1:0] M_INT = NUM_W'(N_INT - 1);
    localparam logic [NUM_W-1:0] M_FP  = NUM_W'(N_FP - 1);
    localparam logic [NUM_W-1:0] M_PR  = NUM_W'(N_PR - 1);
    localparam logic [NUM_W-1:0] M_BR  = NUM_W'(N_BR - 1);
    localparam logic [NUM_W-1:0] M_AR  = NUM_W'(N_AR - 1);

    logic             known;
    logic             is_const;
    logic [IDX_W-1:0] base;

    always_comb begin
        known    = 1'b1;
        is_const = 1'b0;
        base     = '0;
        num_m    = r.num;
        case (r.cls)
            RC_INT: begin
                num_m    = r.num & M_INT;
                is_const = (num_m == '0);
            end
            RC_FP: begin
                num_m    = r.num & M_FP;
                base     = B_FP;
                is_const = (num_m <= NUM_W'(1));
            end
            RC_PR: begin
                num_m    = r.num & M_PR;
                base     = B_PR;
                is_const = (num_m == '0);
            end
            RC_BR: begin
                num_m = r.num & M_BR;
                base  = B_BR;
            end
            RC_AR: begin
                num_m = r.num & M_AR;
                base  = B_AR;
            end
            default: known = 1'b0;
        endcase
        idx  = base + IDX_W'(num_m);
        live = r.vld & known & ~is_const;
    end

endmodule

// File: rtl/hzd_slot_check.sv
module hzd_slot_check
    import hzd_pkg::*;
#(
    parameter int N_INT = 128,
    parameter int N_FP  = 128,
    parameter int N_PR  = 64,
    parameter int N_BR  = 8,
    parameter int N_AR  = 128,
    localparam int TOT   = N_INT + N_FP + N_PR + N_BR + N_AR,
    localparam int IDX_W = $clog2(TOT)
) (
    input  logic [TOT-1:0]   set_in,
    input  logic             slot_vld,
    input  logic             stop,
    input  logic [QP_W-1:0]  qp,
    input  rref_t            dst,
    input  rref_t            sa,
    input  rref_t            sb,
    output logic             hit,
    output logic             kind,
    output logic [CLS_W-1:0] hcls,
    output logic [NUM_W-1:0] hnum,
    output logic [TOT-1:0]   set_out
);

    localparam int NREF = 4;   // qp, source A, source B, destination

    rref_t            refs [NREF];
    logic [IDX_W-1:0] idx  [NREF];
    logic [NUM_W-1:0] nm   [NREF];
    logic [NREF-1:0]  live;
    logic [TOT-1:0]   set_mid;

    always_comb begin
        refs[0] = '{vld: slot_vld, cls: RC_PR, num: NUM_W'(qp)};
        refs[1] = '{vld: slot_vld & sa.vld,  cls: sa.cls,  num: sa.num};
        refs[2] = '{vld: slot_vld & sb.vld,  cls: sb.cls,  num: sb.num};
        refs[3] = '{vld: slot_vld & dst.vld, cls: dst.cls, num: dst.num};
    end

    for (genvar i = 0; i < NREF; i++) begin : g_map
        hzd_regmap #(
            .N_INT(N_INT), .N_FP(N_FP), .N_PR(N_PR), .N_BR(N_BR), .N_AR(N_AR)
        ) u_map (
            .r    (refs[i]),
            .idx  (idx[i]),
            .live (live[i]),
            .num_m(nm[i])
        );
    end

    // Sources in fixed order first, then the destination.
    always_comb begin
        hit  = 1'b0;
        kind = VK_RAW;
        hcls = '0;
        hnum = '0;
        for (int i = 0; i < NREF - 1; i++) begin
            if (!hit && live[i] && set_in[idx[i]]) begin
                hit  = 1'b1;
                kind = VK_RAW;
                hcls = refs[i].cls;
                hnum = nm[i];
            end
        end
        if (!hit && live[NREF-1] && set_in[idx[NREF-1]]) begin
            hit  = 1'b1;
            kind = VK_WAW;
            hcls = refs[NREF-1].cls;
            hnum = nm[NREF-1];
        end
    end

    always_comb begin
        set_mid = set_in;
        if (live[NREF-1]) begin
            set_mid[idx[NREF-1]] = 1'b1;
        end
        set_out = stop ? '0 : set_mid;
    end

endmodule

// File: rtl/hzd_wrset.sv
module hzd_wrset #(
    parameter int TOT = 456
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [TOT-1:0] d,
    output logic [TOT-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/hzd_group_checker.sv
module hzd_group_checker
    import hzd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_INT = 128,
    parameter int N_FP  = 128,
    parameter int N_PR  = 64,
    parameter int N_BR  = 8,
    parameter int N_AR  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd_valid,
    input  logic [127:0]     bnd_raw,
    input  logic [2:0]       slot_valid,
    input  logic [2:0]       slot_stop,
    input  logic [2:0]       dst_vld,
    input  logic [8:0]       dst_cls,
    input  logic [20:0]      dst_num,
    input  logic [2:0]       srca_vld,
    input  logic [8:0]       srca_cls,
    input  logic [20:0]      srca_num,
    input  logic [2:0]       srcb_vld,
    input  logic [8:0]       srcb_cls,
    input  logic [20:0]      srcb_num,
    output logic             viol_pulse,
    output logic             viol_kind,
    output logic [1:0]       viol_slot,
    output logic [2:0]       viol_cls,
    output logic [6:0]       viol_num,
    output logic [CNT_W-1:0] viol_bundle
);

    localparam int TOT = N_INT + N_FP + N_PR + N_BR + N_AR;

    // Slot decode and the in-cycle slot chain
    rref_t            dref [SLOTS];
    rref_t            aref [SLOTS];
    rref_t            bref [SLOTS];
    logic [QP_W-1:0]  qpf  [SLOTS];
    logic [TOT-1:0]   set_chain [SLOTS+1];
    logic [SLOTS-1:0] s_hit;
    logic [SLOTS-1:0] s_kind;
    logic [CLS_W-1:0] s_cls [SLOTS];
    logic [NUM_W-1:0] s_num [SLOTS];
    logic [TOT-1:0]   wset_q;

    logic unused_raw;
    assign unused_raw = ^bnd_raw;

    assign set_chain[0] = wset_q;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign dref[k] = '{vld: dst_vld[k],
                           cls: dst_cls[CLS_W*k +: CLS_W],
                           num: dst_num[NUM_W*k +: NUM_W]};
        assign aref[k] = '{vld: srca_vld[k],
                           cls: srca_cls[CLS_W*k +: CLS_W],
                           num: srca_num[NUM_W*k +: NUM_W]};
        assign bref[k] = '{vld: srcb_vld[k],
                           cls: srcb_cls[CLS_W*k +: CLS_W],
                           num: srcb_num[NUM_W*k +: NUM_W]};
        assign qpf[k]  = bnd_raw[TMPL_W + SLOT_W*k +: QP_W];

        hzd_slot_check #(
            .N_INT(N_INT), .N_FP(N_FP), .N_PR(N_PR), .N_BR(N_BR), .N_AR(N_AR)
        ) u_chk (
            .set_in  (set_chain[k]),
            .slot_vld(slot_valid[k]),
            .stop    (slot_stop[k]),
            .qp      (qpf[k]),
            .dst     (dref[k]),
            .sa      (aref[k]),
            .sb      (bref[k]),
            .hit     (s_hit[k]),
            .kind    (s_kind[k]),
            .hcls    (s_cls[k]),
            .hnum    (s_num[k]),
            .set_out (set_chain[k+1])
        );
    end

    hzd_wrset #(.TOT(TOT)) u_wset (
        .clk  (clk),
        .rst_n(rst_n),
        .load (bnd_valid),
        .d    (set_chain[SLOTS]),
        .q    (wset_q)
    );

    // Lowest slot with a hazard is reported
    logic             any_hit;
    logic             sel_kind;
    logic [1:0]       sel_slot;
    logic [CLS_W-1:0] sel_cls;
    logic [NUM_W-1:0] sel_num;

    always_comb begin
        any_hit  = 1'b0;
        sel_kind = 1'b0;
        sel_slot = '0;
        sel_cls  = '0;
        sel_num  = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (s_hit[k]) begin
                any_hit  = 1'b1;
                sel_kind = s_kind[k];
                sel_slot = 2'(k);
                sel_cls  = s_cls[k];
                sel_num  = s_num[k];
            end
        end
    end

    // Group state machine: EMPTY holds no pending writes, OPEN holds some.
    // T_OPEN:  EMPTY -> OPEN  when an accepted bundle leaves writes after its last stop.
    // T_CLOSE: OPEN  -> EMPTY when an accepted bundle leaves no writes pending.
    gstate_e st_q;
    gstate_e st_d;
    logic    grp_left;
    logic    grp_empty;
    logic    wset_any;

    assign grp_left  = |set_chain[SLOTS];
    assign grp_empty = (st_q == GS_EMPTY);
    assign wset_any  = |wset_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GS_EMPTY: if (bnd_valid && grp_left)  st_d = GS_OPEN;
            GS_OPEN:  if (bnd_valid && !grp_left) st_d = GS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GS_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // Output and bundle index process
    logic [CNT_W-1:0] bnd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bnd_cnt     <= '0;
            viol_pulse  <= 1'b0;
            viol_kind   <= 1'b0;
            viol_slot   <= '0;
            viol_cls    <= '0;
            viol_num    <= '0;
            viol_bundle <= '0;
        end else begin
            viol_pulse <= bnd_valid & any_hit;
            if (bnd_valid) begin
                bnd_cnt <= bnd_cnt + 1'b1;
            end
            if (bnd_valid && any_hit) begin
                viol_kind   <= sel_kind;
                viol_slot   <= sel_slot;
                viol_cls    <= sel_cls;
                viol_num    <= sel_num;
                viol_bundle <= bnd_cnt;
            end
        end
    end

endmodule

// File: rtl/hzd_group_checker_sva.sv
module hzd_group_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       bnd_valid,
    input logic [2:0] slot_stop,
    input logic       viol_pulse,
    input logic [1:0] viol_slot,
    input logic [2:0] viol_cls,
    input logic [6:0] viol_num,
    input logic       grp_empty,
    input logic       wset_any
);

    assert_pulse_has_bundle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> $past(bnd_valid));

    assert_idle_no_report_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_valid |=> !viol_pulse);

    assert_idle_keeps_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_valid |=> $stable(grp_empty));

    assert_slot_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> viol_slot <= 2'd2);

    assert_class_known_R8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> viol_cls <= 3'd4);

    assert_int_pred_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_pulse && (viol_cls == 3'd0 || viol_cls == 3'd2)) |-> viol_num != 7'd0);

    assert_fp_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_pulse && viol_cls == 3'd1) |-> viol_num >= 7'd2);

    assert_last_stop_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && slot_stop[2]) |=> grp_empty);

    assert_empty_has_no_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        grp_empty |-> !wset_any);

endmodule

bind hzd_group_checker hzd_group_checker_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bnd_valid (bnd_valid),
    .slot_stop (slot_stop),
    .viol_pulse(viol_pulse),
    .viol_slot (viol_slot),
    .viol_cls  (viol_cls),
    .viol_num  (viol_num),
    .grp_empty (grp_empty),
    .wset_any  (wset_any)
);

// File: tb/hzd_group_checker_bench.sv
`timescale 1ns/1ps
module hzd_group_checker_bench;

    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bnd_valid = 1'b0;
    logic [127:0]  bnd_raw;
    logic [2:0]    slot_valid, slot_stop;
    logic [2:0]    dst_vld, srca_vld, srcb_vld;
    logic [8:0]    dst_cls, srca_cls, srcb_cls;
    logic [20:0]   dst_num, srca_num, srcb_num;
    logic          viol_pulse, viol_kind;
    logic [1:0]    viol_slot;
    logic [2:0]    viol_cls;
    logic [6:0]    viol_num;
    logic [CW-1:0] viol_bundle;

    int total = 0;
    int bad   = 0;
    int nb    = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    hzd_group_checker #(.CNT_W(CW)) u_hzd_group_checker (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_raw(bnd_raw),
        .slot_valid(slot_valid), .slot_stop(slot_stop),
        .dst_vld(dst_vld), .dst_cls(dst_cls), .dst_num(dst_num),
        .srca_vld(srca_vld), .srca_cls(srca_cls), .srca_num(srca_num),
        .srcb_vld(srcb_vld), .srcb_cls(srcb_cls), .srcb_num(srcb_num),
        .viol_pulse(viol_pulse), .viol_kind(viol_kind), .viol_slot(viol_slot),
        .viol_cls(viol_cls), .viol_num(viol_num), .viol_bundle(viol_bundle)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Template and unused slot bits all ones; qp fields zero.
    task automatic clr();
        bnd_raw = '1;
        for (int k = 0; k < 3; k++) bnd_raw[5 + 41*k +: 6] = 6'd0;
        slot_valid = 3'b111; slot_stop = '0;
        dst_vld = '0; srca_vld = '0; srcb_vld = '0;
        dst_cls = '0; srca_cls = '0; srcb_cls = '0;
        dst_num = '0; srca_num = '0; srcb_num = '0;
    endtask

    task automatic wr(input int k, input int c, input int n);
        dst_vld[k] = 1'b1; dst_cls[3*k +: 3] = 3'(c); dst_num[7*k +: 7] = 7'(n);
    endtask
    task automatic rda(input int k, input int c, input int n);
        srca_vld[k] = 1'b1; srca_cls[3*k +: 3] = 3'(c); srca_num[7*k +: 7] = 7'(n);
    endtask
    task automatic rdb(input int k, input int c, input int n);
        srcb_vld[k] = 1'b1; srcb_cls[3*k +: 3] = 3'(c); srcb_num[7*k +: 7] = 7'(n);
    endtask
    task automatic qps(input int k, input int v);
        bnd_raw[5 + 41*k +: 6] = 6'(v);
    endtask

    // Present one bundle, then check the registered report one edge later.
    task automatic send(input bit ep, input int ek, input int es, input int ec,
                        input int en, input string tag);
        @(negedge clk);
        bnd_valid = 1'b1;
        @(posedge clk);
        #1;
        bnd_valid = 1'b0;
        chk({tag, " pulse"}, int'(viol_pulse), int'(ep));
        if (ep) begin
            chk({tag, " kind"},   int'(viol_kind), ek);
            chk({tag, " slot"},   int'(viol_slot), es);
            chk({tag, " class"},  int'(viol_cls),  ec);
            chk({tag, " number"}, int'(viol_num),  en);
            chk({tag, " bundle R10"}, int'(viol_bundle), nb % (1 << CW));
        end
        nb++;
    endtask

    task automatic close_grp();
        clr(); slot_valid = '0; slot_stop = 3'b100;
        send(0, 0, 0, 0, 0, "R5 close");
    endtask

    task automatic t_reset();
        chk("R1 no pulse after reset", int'(viol_pulse), 0);
        chk("R1 bundle index reset", int'(viol_bundle), 0);
        clr(); rda(0, 0, 5); rdb(1, 1, 9); qps(2, 3);
        send(0, 0, 0, 0, 0, "R1 empty group");
        close_grp();
    endtask

    task automatic t_raw();
        clr(); wr(0, 0, 10); rda(1, 0, 10);
        send(1, 0, 1, 0, 10, "R2 same bundle");
        close_grp();
        clr(); wr(0, 1, 20);
        send(0, 0, 0, 0, 0, "R2 write only");
        clr(); rdb(2, 1, 20);
        send(1, 0, 2, 1, 20, "R2 across bundles");
        close_grp();
    endtask

    task automatic t_waw();
        clr(); wr(0, 2, 7); wr(2, 2, 7);
        send(1, 1, 2, 2, 7, "R3 pred rewrite");
        close_grp();
        clr(); wr(1, 4, 33);
        send(0, 0, 0, 0, 0, "R3 first write");
        clr(); wr(0, 4, 33);
        send(1, 1, 0, 4, 33, "R3 next bundle");
        close_grp();
    endtask

    task automatic t_legal();
        clr(); rda(0, 0, 3); rdb(1, 0, 3); wr(1, 0, 4);
        rda(2, 0, 3); wr(2, 0, 3);
        send(0, 0, 0, 0, 0, "R4 RAR WAR self");
        close_grp();
    endtask

    task automatic t_stop();
        clr(); wr(0, 0, 9); slot_stop[0] = 1'b1; rda(1, 0, 9);
        send(0, 0, 0, 0, 0, "R5 stop slot0");
        close_grp();
        clr(); wr(0, 0, 11); slot_valid[1] = 1'b0; slot_stop[1] = 1'b1; rda(2, 0, 11);
        send(0, 0, 0, 0, 0, "R5 stop on invalid slot");
        clr(); wr(0, 3, 2); slot_stop[2] = 1'b1;
        send(0, 0, 0, 0, 0, "R5 stop slot2");
        clr(); rda(0, 3, 2);
        send(0, 0, 0, 0, 0, "R5 next bundle new group");
        close_grp();
    endtask

    task automatic t_qp();
        clr(); wr(0, 2, 5); qps(1, 5);
        send(1, 0, 1, 2, 5, "R6 qp slot1");
        close_grp();
        clr(); wr(0, 2, 6); qps(2, 6);
        send(1, 0, 2, 2, 6, "R6 qp slot2");
        close_grp();
        clr(); wr(1, 2, 40); qps(0, 40);
        send(0, 0, 0, 0, 0, "R6 qp read before write");
        close_grp();
    endtask

    task automatic t_const();
        clr(); wr(0, 0, 0); wr(1, 1, 1); rda(1, 0, 0);
        rda(2, 1, 1); rdb(2, 1, 0); wr(2, 0, 0);
        send(0, 0, 0, 0, 0, "R7 r0 f0 f1");
        clr(); wr(0, 2, 0); qps(1, 0); wr(2, 2, 0);
        send(0, 0, 0, 0, 0, "R7 p0");
        close_grp();
    endtask

    task automatic t_class();
        clr(); wr(0, 0, 12); rda(1, 1, 12); rdb(1, 4, 12); rda(2, 5, 12);
        wr(2, 6, 12);
        send(0, 0, 0, 0, 0, "R8 class separation");
        close_grp();
        clr(); wr(0, 3, 12); rda(1, 3, 4);
        send(1, 0, 1, 3, 4, "R8 branch modulo");
        close_grp();
        clr(); wr(0, 2, 70); rdb(2, 2, 6);
        send(1, 0, 2, 2, 6, "R8 pred modulo");
        close_grp();
    endtask

    task automatic t_prio();
        clr(); wr(0, 0, 20); wr(1, 0, 21); rda(2, 0, 21); rdb(2, 0, 20); wr(2, 0, 20);
        send(1, 0, 2, 0, 21, "R9 source A first");
        close_grp();
        clr(); wr(0, 0, 22); rdb(1, 0, 22); rda(2, 0, 22);
        send(1, 0, 1, 0, 22, "R9 lowest slot");
        close_grp();
        clr(); wr(0, 0, 31); rda(1, 0, 31); wr(1, 0, 32);
        send(1, 0, 1, 0, 31, "R9 violating slot");
        clr(); rda(0, 0, 32);
        send(1, 0, 0, 0, 32, "R9 write still recorded");
        close_grp();
        clr(); wr(0, 1, 50); qps(1, 9); wr(0, 1, 50); wr(1, 1, 50); rda(1, 1, 50);
        send(1, 0, 1, 1, 50, "R9 read before write in slot");
        close_grp();
    endtask

    task automatic t_invalid();
        clr(); wr(0, 0, 40); slot_valid[0] = 1'b0; rda(1, 0, 40);
        send(0, 0, 0, 0, 0, "R11 invalid slot write");
        close_grp();
        clr(); wr(0, 0, 41);
        @(negedge clk);
        @(posedge clk);
        #1;
        chk("R11 idle no pulse", int'(viol_pulse), 0);
        clr(); rda(0, 0, 41);
        send(0, 0, 0, 0, 0, "R11 idle wrote nothing");
        clr(); wr(0, 0, 42); rda(2, 0, 42);
        send(1, 0, 2, 0, 42, "R10 index after idle");
        close_grp();
    endtask

    task automatic t_wrap();
        while (nb < 70) close_grp();
        clr(); wr(0, 4, 1); wr(1, 4, 1);
        send(1, 1, 1, 4, 1, "R10 index wrap");
        close_grp();
    endtask

    initial begin
        clr();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        t_reset();
        t_raw();
        t_waw();
        t_legal();
        t_stop();
        t_qp();
        t_const();
        t_class();
        t_prio();
        t_invalid();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule